// File: doc/BRIEF.md
# PCI Bus Master Single-Word Transfer Engine

This block turns one local request at a time into a single-data-phase memory read or memory write on a 32-bit PCI bus. It asks for the bus with one request line, waits for its grant and an idle bus, then drives the address phase and one data phase. The target can end that data phase in four ways: it completes it, it asks for a retry, it never claims the cycle, or it claims it and then stalls. The block handles each case and reports one outcome to the local requester, along with the read data when a read completes.

Two watchdogs bound the time spent on a transfer. Each has its own enable bit. The first is a data-phase wait counter: if the target raises neither TRDY# nor STOP# within a programmed number of clocks, the transfer is abandoned. The second is a retry counter: it limits how many retry terminations are tolerated. After each retry the engine releases the bus, asks for it again, and reissues the same address and command. A target that never asserts DEVSEL# is treated as a master abort and gets its own status code. The engine never places two of its own transactions back to back without an idle bus cycle between them.

Top module: `pcim_xfer_engine`

## Requirements
- R1: During and right after reset, the engine is in this state: bus_req_n=1, ctl_oe=0, ad_oe=0, par_oe=0, busy=0 and done_valid=0.
- R2: A request taken while idle drives bus_req_n low from the next cycle. The address phase starts only in the cycle after an edge at which bus_gnt_n=0, frame_n_i=1 and irdy_n_i=1.
- R3: The address phase lasts one cycle, with frame_n_o=0, ad_o=address and cbe_n_o=0110 for a read or 0111 for a write. In the data phase that follows, frame_n_o=1, irdy_n_o=0 and cbe_n_o=0000, and a write drives its data on ad_o.
- R4: In every cycle that follows a cycle in which ad_oe=1, par_oe=1 and par_o equals the XOR of the ad_o and cbe_n_o values from that earlier cycle.
- R5: If TRDY# and DEVSEL# are both low at a data-phase edge, the transfer ends with done_status=0 (success). A read returns the ad_i value sampled at that edge on done_rdata.
- R6: If STOP# is low with TRDY# high and DEVSEL# low, and the retry limit is not reached, the engine releases the bus, requests it again, and reissues the same address and command.
- R7: With the retry limit enabled at value L, the retry termination that brings the count to L (or the first one when L=0) ends the transfer with done_status=2. With the limit disabled, retries continue without bound.
- R8: With the wait timeout enabled at value L, a data phase that sees no TRDY# or STOP# ends with done_status=1 after exactly L data-phase cycles. A TRDY# in the L-th cycle still completes normally.
- R9: With the wait timeout disabled, the engine waits in the data phase for as long as the target takes.
- R10: If DEVSEL# is not seen low at the edges of the first five data-phase cycles, the transfer ends with done_status=3 after five data-phase cycles.
- R11: Every data phase is followed by one turnaround cycle. In it the engine still drives FRAME# and IRDY#, both high, and done_valid pulses for exactly that cycle when the transfer is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Local request strobe, taken while idle |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | A transfer is in progress |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 wait timeout, 2 retry limit, 3 master abort |
| done_rdata | output | 32 | Read data of a successful read |
| cfg_wait_en | input | 1 | Enables the data-phase wait timeout |
| cfg_wait_limit | input | 8 | Data-phase cycles allowed |
| cfg_retry_en | input | 1 | Enables the retry limit |
| cfg_retry_limit | input | 8 | Retry terminations allowed |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| frame_n_i | input | 1 | Observed FRAME# |
| irdy_n_i | input | 1 | Observed IRDY# |
| devsel_n_i | input | 1 | Target DEVSEL# |
| trdy_n_i | input | 1 | Target TRDY# |
| stop_n_i | input | 1 | Target STOP# |
| ad_i | input | 32 | Observed AD bus |
| ctl_oe | output | 1 | Drive enable for FRAME#, IRDY#, C/BE# |
| frame_n_o | output | 1 | Driven FRAME# |
| irdy_n_o | output | 1 | Driven IRDY# |
| cbe_n_o | output | 4 | Driven command / byte enables |
| ad_oe | output | 1 | Drive enable for AD |
| ad_o | output | 32 | Driven AD value |
| par_oe | output | 1 | Drive enable for PAR |
| par_o | output | 1 | Driven PAR |

## Verification
The target response seen at a data-phase edge shows up as done_valid and done_status one cycle later, in the turnaround cycle. Parity lags the AD cycle it covers by one cycle. bus_req_n falls one cycle after a request is taken. The bench drives the target model and the grant on falling edges. It reads the registered outputs on the falling edge that follows the rising edge which produced them, so each result is checked in the cycle it is due. The bench also counts data-phase cycles and address phases for each transfer and compares those counts with the exact values the timeout, master-abort and retry rules predict.

// File: rtl/pcim_pkg.sv
package pcim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_TURN = 3'd4
    } xfer_st_e;

    typedef enum logic [1:0] {
        XS_OK     = 2'd0,
        XS_WAIT   = 2'd1,
        XS_RETRY  = 2'd2,
        XS_MABORT = 2'd3
    } xfer_status_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pcim_wait_ctr.sv
module pcim_wait_ctr #(
    parameter int W      = 8,
    parameter int WINDOW = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         cfg_en,
    input  logic [W-1:0] cfg_limit,
    output logic         wait_hit,
    output logic         win_end
);
    localparam int            WIN_LAST_I = WINDOW - 1;
    localparam logic [W-1:0]  WIN_LAST   = WIN_LAST_I[W-1:0];

    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   cnt_inc;

    assign cnt_inc  = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign wait_hit = cfg_en && (cnt_inc >= {1'b0, cfg_limit});
    assign win_end  = (cnt_q == WIN_LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q != {W{1'b1}})
            cnt_d = cnt_inc[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pcim_retry_ctr.sv
module pcim_retry_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  logic         cfg_en,
    input  logic [W-1:0] cfg_limit,
    output logic         limit_hit
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   cnt_inc;

    assign cnt_inc   = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign limit_hit = cfg_en && (cnt_inc >= {1'b0, cfg_limit});

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (inc && cnt_q != {W{1'b1}})
            cnt_d = cnt_inc[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pcim_par_gen.sv
module pcim_par_gen #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad,
    input  logic [3:0]    cbe_n,
    input  logic          drive,
    output logic          par,
    output logic          par_oe
);
    typedef struct packed {
        logic par;
        logic oe;
    } par_t;

    par_t par_d, par_q;

    always_comb begin
        par_d.par = ^{ad, cbe_n};
        par_d.oe  = drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign par    = par_q.par;
    assign par_oe = par_q.oe;
endmodule

// File: rtl/pcim_xfer_engine.sv
module pcim_xfer_engine
    import pcim_pkg::*;
#(
    parameter int DW            = 32,
    parameter int WAIT_W        = 8,
    parameter int RETRY_W       = 8,
    parameter int DEVSEL_WINDOW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [DW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               busy,
    output logic               done_valid,
    output logic [1:0]         done_status,
    output logic [DW-1:0]      done_rdata,
    input  logic               cfg_wait_en,
    input  logic [WAIT_W-1:0]  cfg_wait_limit,
    input  logic               cfg_retry_en,
    input  logic [RETRY_W-1:0] cfg_retry_limit,
    output logic               bus_req_n,
    input  logic               bus_gnt_n,
    input  logic               frame_n_i,
    input  logic               irdy_n_i,
    input  logic               devsel_n_i,
    input  logic               trdy_n_i,
    input  logic               stop_n_i,
    input  logic [DW-1:0]      ad_i,
    output logic               ctl_oe,
    output logic               frame_n_o,
    output logic               irdy_n_o,
    output logic [3:0]         cbe_n_o,
    output logic               ad_oe,
    output logic [DW-1:0]      ad_o,
    output logic               par_oe,
    output logic               par_o
);
    typedef struct packed {
        xfer_st_e      st;
        logic          write;
        logic [DW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          again;
        logic          done_valid;
        xfer_status_e  status;
    } eng_t;

    eng_t eng_d, eng_q;

    logic retry_clr, retry_inc, retry_hit;
    logic wait_hit, win_end;
    logic hit_trdy, hit_stop;

    assign hit_trdy = !devsel_n_i && !trdy_n_i;
    assign hit_stop = !devsel_n_i && trdy_n_i && !stop_n_i;

    pcim_wait_ctr #(.W(WAIT_W), .WINDOW(DEVSEL_WINDOW)) i_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_q.st == ST_DATA),
        .cfg_en    (cfg_wait_en),
        .cfg_limit (cfg_wait_limit),
        .wait_hit  (wait_hit),
        .win_end   (win_end)
    );

    pcim_retry_ctr #(.W(RETRY_W)) i_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (retry_clr),
        .inc       (retry_inc),
        .cfg_en    (cfg_retry_en),
        .cfg_limit (cfg_retry_limit),
        .limit_hit (retry_hit)
    );

    always_comb begin
        eng_d            = eng_q;
        eng_d.done_valid = 1'b0;
        retry_clr        = 1'b0;
        retry_inc        = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    eng_d.st    = ST_REQ;
                    eng_d.write = req_write;
                    eng_d.addr  = req_addr;
                    eng_d.wdata = req_wdata;
                    eng_d.again = 1'b0;
                    retry_clr   = 1'b1;
                end
            end
            ST_REQ: begin
                if (!bus_gnt_n && frame_n_i && irdy_n_i)
                    eng_d.st = ST_ADDR;
            end
            ST_ADDR: eng_d.st = ST_DATA;
            ST_DATA: begin
                if (hit_trdy) begin
                    eng_d.st         = ST_TURN;
                    eng_d.again      = 1'b0;
                    eng_d.done_valid = 1'b1;
                    eng_d.status     = XS_OK;
                    if (!eng_q.write)
                        eng_d.rdata = ad_i;
                end else if (hit_stop) begin
                    retry_inc = 1'b1;
                    eng_d.st  = ST_TURN;
                    if (retry_hit) begin
                        eng_d.again      = 1'b0;
                        eng_d.done_valid = 1'b1;
                        eng_d.status     = XS_RETRY;
                    end else begin
                        eng_d.again = 1'b1;
                    end
                end else if (devsel_n_i && win_end) begin
                    eng_d.st         = ST_TURN;
                    eng_d.again      = 1'b0;
                    eng_d.done_valid = 1'b1;
                    eng_d.status     = XS_MABORT;
                end else if (wait_hit) begin
                    eng_d.st         = ST_TURN;
                    eng_d.again      = 1'b0;
                    eng_d.done_valid = 1'b1;
                    eng_d.status     = XS_WAIT;
                end
            end
            ST_TURN: eng_d.st = eng_q.again ? ST_REQ : ST_IDLE;
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy        = (eng_q.st != ST_IDLE);
    assign done_valid  = eng_q.done_valid;
    assign done_status = eng_q.status;
    assign done_rdata  = eng_q.rdata;
    assign bus_req_n   = (eng_q.st != ST_REQ);
    assign ctl_oe      = (eng_q.st == ST_ADDR) || (eng_q.st == ST_DATA) || (eng_q.st == ST_TURN);
    assign frame_n_o   = (eng_q.st != ST_ADDR);
    assign irdy_n_o    = (eng_q.st != ST_DATA);
    assign cbe_n_o     = (eng_q.st == ST_ADDR) ? (eng_q.write ? CMD_MEM_WR : CMD_MEM_RD) : 4'b0000;
    assign ad_oe       = (eng_q.st == ST_ADDR) || ((eng_q.st == ST_DATA) && eng_q.write);
    assign ad_o        = (eng_q.st == ST_ADDR) ? eng_q.addr : eng_q.wdata;

    pcim_par_gen #(.DW(DW)) i_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .ad     (ad_o),
        .cbe_n  (cbe_n_o),
        .drive  (ad_oe),
        .par    (par_o),
        .par_oe (par_oe)
    );
endmodule

// File: rtl/pcim_xfer_engine_chk.sv
module pcim_xfer_engine_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req_n,
    input logic          bus_gnt_n,
    input logic          frame_n_i,
    input logic          irdy_n_i,
    input logic          devsel_n_i,
    input logic          cfg_wait_en,
    input logic          ctl_oe,
    input logic          frame_n_o,
    input logic          irdy_n_o,
    input logic [3:0]    cbe_n_o,
    input logic          ad_oe,
    input logic [DW-1:0] ad_o,
    input logic          par_oe,
    input logic          par_o,
    input logic          done_valid,
    input logic [1:0]    done_status,
    input logic          busy
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (bus_req_n && !ctl_oe && !ad_oe && !busy));

    // R2
    start_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n_o) |-> $past(!bus_gnt_n && frame_n_i && irdy_n_i));

    // R3
    single_addr_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n_o |=> (frame_n_o && !irdy_n_o));

    // R4
    parity_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ad_oe) |-> (par_oe && par_o == ^{$past(ad_o), $past(cbe_n_o)}));

    // R10
    mabort_no_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == 2'd3) |-> $past(devsel_n_i));

    // R9
    wait_off_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status == 2'd1) |-> $past(cfg_wait_en));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R11
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irdy_n_o) |-> (ctl_oe && frame_n_o));
endmodule

bind pcim_xfer_engine pcim_xfer_engine_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_pcim_xfer_engine.sv
module test_pcim_xfer_engine;
    localparam logic [31:0] RD_KEY = 32'hA5A5_0F0F;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [3:0]  gnt_dly;
        logic [3:0]  busy_cyc;
        logic [3:0]  dsel_dly;
        logic [1:0]  kind;
        logic [3:0]  resp_dly;
        logic [3:0]  nretry;
        logic        wait_en;
        logic [7:0]  wait_lim;
        logic        retry_en;
        logic [7:0]  retry_lim;
        logic [1:0]  exp_st;
        logic [3:0]  exp_phases;
        logic [4:0]  exp_dcyc;
    } vec_t;

    // kind: 0 TRDY, 1 STOP, 2 no response; dsel_dly 15 = never claims
    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 32'h1000_0040, 32'hDEAD_BEEF, 4'd0, 4'd0, 4'd0,  2'd0, 4'd0,  4'd0,  1'b1, 8'd8,  1'b1, 8'd4, 2'd0, 4'd1, 5'd1},  // R5 write
        '{1'b0, 32'h2000_0104, 32'h0,         4'd3, 4'd3, 4'd2,  2'd0, 4'd3,  4'd0,  1'b1, 8'd10, 1'b1, 8'd4, 2'd0, 4'd1, 5'd4},  // R2 R5 read
        '{1'b0, 32'h0000_0A08, 32'h0,         4'd1, 4'd0, 4'd0,  2'd0, 4'd1,  4'd2,  1'b1, 8'd8,  1'b1, 8'd5, 2'd0, 4'd3, 5'd2},  // R6
        '{1'b1, 32'h3000_0010, 32'h1234_5678, 4'd0, 4'd0, 4'd1,  2'd1, 4'd1,  4'd15, 1'b1, 8'd8,  1'b1, 8'd3, 2'd2, 4'd3, 5'd2},  // R7
        '{1'b0, 32'h4000_0000, 32'h0,         4'd0, 4'd0, 4'd0,  2'd0, 4'd0,  4'd6,  1'b1, 8'd8,  1'b0, 8'd1, 2'd0, 4'd7, 5'd1},  // R7 disabled
        '{1'b1, 32'h5000_0020, 32'hCAFE_F00D, 4'd0, 4'd0, 4'd0,  2'd2, 4'd0,  4'd0,  1'b1, 8'd6,  1'b1, 8'd4, 2'd1, 4'd1, 5'd6},  // R8
        '{1'b0, 32'h6000_0030, 32'h0,         4'd0, 4'd0, 4'd15, 2'd0, 4'd0,  4'd0,  1'b0, 8'd2,  1'b1, 8'd4, 2'd3, 4'd1, 5'd5},  // R10
        '{1'b0, 32'h7000_0044, 32'h0,         4'd0, 4'd0, 4'd1,  2'd0, 4'd12, 4'd0,  1'b0, 8'd3,  1'b1, 8'd4, 2'd0, 4'd1, 5'd13}, // R9
        '{1'b1, 32'h8000_0008, 32'h0F0F_1234, 4'd0, 4'd0, 4'd0,  2'd0, 4'd2,  4'd0,  1'b1, 8'd3,  1'b1, 8'd4, 2'd0, 4'd1, 5'd3},  // R8 boundary
        '{1'b0, 32'h9000_000C, 32'h0,         4'd0, 4'd0, 4'd15, 2'd0, 4'd0,  4'd0,  1'b1, 8'd2,  1'b1, 8'd4, 2'd1, 4'd1, 5'd2},  // R8 before R10
        '{1'b1, 32'hA000_0050, 32'h0000_0001, 4'd0, 4'd0, 4'd0,  2'd1, 4'd0,  4'd1,  1'b1, 8'd8,  1'b1, 8'd0, 2'd2, 4'd1, 5'd1}   // R7 zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        busy, done_valid;
    logic [1:0]  done_status;
    logic [31:0] done_rdata;
    logic        cfg_wait_en = 1'b0, cfg_retry_en = 1'b0;
    logic [7:0]  cfg_wait_limit = '0, cfg_retry_limit = '0;
    logic        bus_req_n, bus_gnt_n = 1'b1;
    logic        frame_n_i = 1'b1, irdy_n_i = 1'b1;
    logic        devsel_n_i = 1'b1, trdy_n_i = 1'b1, stop_n_i = 1'b1;
    logic [31:0] ad_i = '0;
    logic        ctl_oe, frame_n_o, irdy_n_o, ad_oe, par_oe, par_o;
    logic [3:0]  cbe_n_o;
    logic [31:0] ad_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pcim_xfer_engine i_pcim_xfer_engine (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string tag);
        logic [5:0] act;
        act = {bus_req_n, ctl_oe, ad_oe, par_oe, busy, done_valid};
        chk(act == 6'b100000, "R1", tag, {26'd0, act}, 32'h20);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int   gnt_cnt = 0, busy_left, phases = 0, dc = -1, last_dcyc = 0, kind_now;
        bit   finished = 0, prev_ad_oe = 0, prev_idle = 1, dsel_on, respond;
        logic [31:0] prev_ad = '0;
        logic [3:0]  prev_cbe = '0;
        busy_left = int'(v.busy_cyc);
        @(negedge clk);
        cfg_wait_en = v.wait_en; cfg_wait_limit = v.wait_lim;
        cfg_retry_en = v.retry_en; cfg_retry_limit = v.retry_lim;
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 400; c++) begin
            if (c == 0) chk(!bus_req_n, "R2", $sformatf("vec%0d request asserted", idx), {31'd0, bus_req_n}, 0);
            if (prev_ad_oe)
                chk(par_oe && par_o == ^{prev_ad, prev_cbe}, "R4", $sformatf("vec%0d parity", idx),
                    {30'd0, par_oe, par_o}, {30'd0, 1'b1, ^{prev_ad, prev_cbe}});
            if (done_valid) begin
                chk(ctl_oe && frame_n_o && irdy_n_o, "R11", $sformatf("vec%0d turnaround", idx),
                    {29'd0, ctl_oe, frame_n_o, irdy_n_o}, 32'h7);
                chk(done_status == v.exp_st, "R5", $sformatf("vec%0d status", idx),
                    {30'd0, done_status}, {30'd0, v.exp_st});
                chk(phases == int'(v.exp_phases), "R6", $sformatf("vec%0d address phases", idx),
                    phases, {28'd0, v.exp_phases});
                chk(last_dcyc == int'(v.exp_dcyc), "R8", $sformatf("vec%0d data cycles", idx),
                    last_dcyc, {27'd0, v.exp_dcyc});
                if (!v.wr && v.exp_st == 2'd0)
                    chk(done_rdata == (v.addr ^ RD_KEY), "R5", $sformatf("vec%0d read data", idx),
                        done_rdata, v.addr ^ RD_KEY);
                finished = 1;
                devsel_n_i = 1'b1; trdy_n_i = 1'b1; stop_n_i = 1'b1; ad_i = '0;
                break;
            end
            if (ctl_oe && !frame_n_o) begin
                phases++;
                dc = -1;
                chk(!bus_gnt_n && frame_n_i && irdy_n_i, "R2", $sformatf("vec%0d start condition", idx),
                    {29'd0, bus_gnt_n, frame_n_i, irdy_n_i}, 32'h3);
                chk(prev_idle, "R11", $sformatf("vec%0d idle before address", idx), 0, 1);
                chk(ad_oe && ad_o == v.addr && cbe_n_o == (v.wr ? 4'b0111 : 4'b0110),
                    phases > 1 ? "R6" : "R3", $sformatf("vec%0d address/command", idx),
                    ad_o, v.addr);
            end else if (ctl_oe && !irdy_n_o) begin
                dc++;
                if (dc == 0) begin
                    chk(frame_n_o && cbe_n_o == 4'b0000, "R3", $sformatf("vec%0d data phase controls", idx),
                        {27'd0, frame_n_o, cbe_n_o}, 32'h10);
                    if (v.wr)
                        chk(ad_oe && ad_o == v.wdata, "R3", $sformatf("vec%0d write data", idx), ad_o, v.wdata);
                end
                dsel_on  = (v.dsel_dly != 4'd15) && (dc >= int'(v.dsel_dly));
                respond  = dsel_on && (dc >= int'(v.resp_dly));
                kind_now = (phases - 1 < int'(v.nretry)) ? 1 : int'(v.kind);
                devsel_n_i = !dsel_on;
                trdy_n_i   = !(respond && kind_now == 0);
                stop_n_i   = !(respond && kind_now == 1);
                ad_i       = (respond && kind_now == 0) ? (v.addr ^ RD_KEY) : '0;
                last_dcyc  = dc + 1;
            end else begin
                devsel_n_i = 1'b1; trdy_n_i = 1'b1; stop_n_i = 1'b1; ad_i = '0;
            end
            prev_idle  = !(ctl_oe && (!frame_n_o || !irdy_n_o));
            prev_ad_oe = ad_oe; prev_ad = ad_o; prev_cbe = cbe_n_o;
            if (!bus_req_n) begin
                if (gnt_cnt >= int'(v.gnt_dly)) bus_gnt_n = 1'b0;
                gnt_cnt++;
            end else begin
                gnt_cnt = 0;
                bus_gnt_n = 1'b1;
            end
            if (!bus_gnt_n && busy_left > 0) begin
                frame_n_i = 1'b0;
                busy_left--;
            end else begin
                frame_n_i = 1'b1;
            end
            @(negedge clk);
        end
        if (!finished) chk(0, "R5", $sformatf("vec%0d never completed", idx), 0, 1);
        bus_gnt_n = 1'b1; frame_n_i = 1'b1;
        @(negedge clk);
        chk(!done_valid, "R11", $sformatf("vec%0d done pulse width", idx), {31'd0, done_valid}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_reset_state("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("after reset");
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);
        // directed: reset in the middle of a transfer returns the R1 state
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'hB000_0000;
        @(negedge clk);
        req_valid = 1'b0; bus_gnt_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset_state("reset mid-transfer");
        bus_gnt_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("after mid-transfer reset");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule